// File: doc/BRIEF.md
# Burst-Mode Synchronous SRAM Core

A single-port synchronous memory whose address, control and write data are captured on the rising clock edge, while read data is not registered: it flows from the array to the output port within the cycle that follows the capturing edge. One starting address can produce four data beats. A 2-bit beat counter inside the block generates the three follow-on addresses, either by counting up within the aligned group of four or by XOR-ing the count into the low two address bits. A mode input selects the order.

A burst starts from either of two strobes. The controller strobe always loads, and it also deselects the block when chip select is inactive. The processor strobe loads only while the block is selected. Writes happen on any selected cycle. A global write updates every byte lane. Otherwise the byte-write enable, together with one select per lane, chooses which lanes are updated. A cycle with neither enable is a read. Output enable and the sleep input act on the output combinationally. Sleep also freezes all state and blocks writes, and the array keeps its contents.

Top module: `bsram_core`

## Requirements
- R1: A low `ctl_strobe_n` loads `addr_i` as the burst start on the next edge, resets the beat count and sets the selected state to the inverse of `sel_n`. It takes priority over `step_n` and over `cpu_strobe_n`.
- R2: A low `cpu_strobe_n` loads the start address only when `sel_n` is low. When `sel_n` is high it is ignored and the selected state does not change.
- R3: Without a load, the beat counter advances on an edge only when the block is selected and `step_n` is low. Otherwise the current beat address is held.
- R4: With `order_i`=0 (linear), beat k uses low address bits (start+k) mod 4. The upper address bits stay unchanged.
- R5: With `order_i`=1 (interleaved), beat k uses low address bits start XOR k.
- R6: Read data is flow-through. After the edge that sets a beat address, `rdata_o` shows the word at that address in the same cycle, with `rvalid_o`=1, when the block is selected, the cycle is not a write, `out_en_n` is low and `sleep_i` is low.
- R7: On a selected edge with `wr_all_n` low, all lanes of `wdata_i` are written to the beat address of that edge.
- R8: On a selected edge with `wr_all_n` high and `wr_lane_en_n` low, only lanes i with `lane_sel_n[i]`=0 are written. Lane i is bits [8i+7:8i].
- R9: With both `wr_all_n` and `wr_lane_en_n` high, the cycle is a read and the array is unchanged.
- R10: `out_en_n` high forces `rvalid_o`=0 and `rdata_o`=0 combinationally, with no clock edge needed.
- R11: While `sleep_i` is high, all synchronous inputs are ignored, no write occurs, the burst state and the array are kept, and `rvalid_o` is 0 combinationally.
- R12: During reset the block is deselected and `rvalid_o` is 0.
- R13: After the fourth beat, a further advance wraps back to the starting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Burst start address |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| sel_n | input | 1 | Chip select, active low |
| step_n | input | 1 | Burst advance, active low |
| order_i | input | 1 | 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_en_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Power-down request, active high |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Flow-through read data, zero when not valid |
| rvalid_o | output | 1 | Read data is driven (low models tri-state) |

## Verification
Two pairs of functions can fall in the same cycle. One pair is a controller-strobe load arriving in the middle of an advancing burst. The other is a write whose beat address is also the address being read through the flow-through path. The bench provokes both on purpose: a controller strobe issued together with `step_n` low during a burst, and a lane write followed by a burst reload of the same address. Random stimulus adds many more collisions, including strobes during sleep. Each cycle is judged against a bench model of the address sequence and memory contents, and directed beats are compared with address-tagged data patterns.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  // low two address bits of beat k for a given start
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv == ORDER_INTERLEAVED) r = start ^ k;
    else                          r = start + k;
    return r;
  endfunction

endpackage

// File: rtl/bsram_rst_sync.sv
module bsram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/bsram_burst_ctl.sv
module bsram_burst_ctl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              ld_ctl,
  input  logic              ld_cpu,
  input  logic              sel_n,
  input  logic              step_n,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              act_d,
  output logic [ADDR_W-1:0] beat_addr_d,
  output logic              act_q,
  output logic [ADDR_W-1:0] beat_addr_q
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (!sleep_i) begin
      if (ld_ctl || ld_cpu) begin
        base_d = addr_i;
        cnt_d  = 2'd0;
        act_d  = ~sel_n;
      end else if (act_q && !step_n) begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      act_q  <= 1'b0;
    end else if (!sleep_i) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign beat_addr_d = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], cnt_d, order_i)};
  assign beat_addr_q = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_q, order_i)};
endmodule

// File: rtl/bsram_lane_gate.sv
module bsram_lane_gate #(
  parameter int LANES = 4
) (
  input  logic             cyc_ok,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = cyc_ok & (~wr_all_n | (~wr_lane_en_n & ~lane_sel_n[i]));
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ctl_strobe_n,
  input  logic              cpu_strobe_n,
  input  logic              sel_n,
  input  logic              step_n,
  input  logic              order_i,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic              sleep_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic              rst_sync_n;
  logic              act_d, act_q;
  logic [ADDR_W-1:0] beat_addr_d, beat_addr;
  logic [LANES-1:0]  lane_we;
  logic              wr_d, wr_q;
  logic [WORD_W-1:0] arr_rdata;

  bsram_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_sync_n)
  );

  bsram_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sleep_i     (sleep_i),
    .ld_ctl      (~ctl_strobe_n),
    .ld_cpu      (~cpu_strobe_n & ~sel_n),
    .sel_n       (sel_n),
    .step_n      (step_n),
    .order_i     (order_i),
    .addr_i      (addr_i),
    .act_d       (act_d),
    .beat_addr_d (beat_addr_d),
    .act_q       (act_q),
    .beat_addr_q (beat_addr)
  );

  bsram_lane_gate #(.LANES(LANES)) u_gate (
    .cyc_ok       (act_d & ~sleep_i & rst_sync_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .lane_we      (lane_we)
  );

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (beat_addr_d),
    .wdata   (wdata_i),
    .raddr   (beat_addr),
    .rdata   (arr_rdata)
  );

  // write-cycle flag: suppresses the read view during a write beat
  always_comb begin
    wr_d = wr_q;
    if (!sleep_i) wr_d = |lane_we;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_q <= 1'b0;
    else             wr_q <= wr_d;
  end

  assign rvalid_o = act_q & ~wr_q & ~out_en_n & ~sleep_i;
  assign rdata_o  = rvalid_o ? arr_rdata : '0;
endmodule

// File: rtl/bsram_core_chk.sv
module bsram_core_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sleep_i,
  input logic              ctl_strobe_n,
  input logic              cpu_strobe_n,
  input logic              sel_n,
  input logic              step_n,
  input logic              order_i,
  input logic              out_en_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              act_q,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              rvalid_o
);
  logic no_load;
  assign no_load = ctl_strobe_n & (cpu_strobe_n | sel_n);

  p_ctl_load_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sleep_i && !ctl_strobe_n) |=> (beat_addr == $past(addr_i)) && (act_q == !$past(sel_n)));

  p_cpu_ignored_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sleep_i && ctl_strobe_n && !cpu_strobe_n && sel_n && !act_q) |=> !act_q);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sleep_i && no_load && step_n && $stable(order_i)) |=> ($stable(beat_addr) || $changed(order_i)) && $stable(act_q));

  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sleep_i && no_load && !step_n && act_q && !order_i) |=>
      (order_i || ((beat_addr[1:0] == $past(beat_addr[1:0]) + 2'd1) &&
                   (beat_addr[ADDR_W-1:2] == $past(beat_addr[ADDR_W-1:2])))));

  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_en_n |-> !rvalid_o);

  p_sleep_out_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sleep_i |-> !rvalid_o);

  p_sleep_freeze_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep_i && $stable(order_i)) |=> ($stable(beat_addr) || $changed(order_i)) && $stable(act_q));
endmodule

bind bsram_core bsram_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .sleep_i      (sleep_i),
  .ctl_strobe_n (ctl_strobe_n),
  .cpu_strobe_n (cpu_strobe_n),
  .sel_n        (sel_n),
  .step_n       (step_n),
  .order_i      (order_i),
  .out_en_n     (out_en_n),
  .addr_i       (addr_i),
  .act_q        (act_q),
  .beat_addr    (beat_addr),
  .rvalid_o     (rvalid_o)
);

// File: tb/bsram_core_tb.sv
`timescale 1ns/1ps
module bsram_core_tb;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int WW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ctl_n, cpu_n, sel_n, step_n, ord, gw_n, bwe_n, oe_n, zz;
  logic [NL-1:0] bsel_n;
  logic [WW-1:0] wd;
  logic [WW-1:0] rdata;
  logic          rvalid;

  bsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ctl_strobe_n(ctl_n),
    .cpu_strobe_n(cpu_n), .sel_n(sel_n), .step_n(step_n), .order_i(ord),
    .wr_all_n(gw_n), .wr_lane_en_n(bwe_n), .lane_sel_n(bsel_n),
    .out_en_n(oe_n), .sleep_i(zz), .wdata_i(wd), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [WW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_act, m_wr;

  function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h3C, 8'h5A};
  endfunction

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic model_edge();
    logic [NL-1:0] we;
    if (!rst_n || zz) return;
    if (!ctl_n || (!cpu_n && !sel_n)) begin
      m_base = addr; m_cnt = 2'd0; m_act = !sel_n;
    end else if (m_act && !step_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    we = '0;
    if (m_act) begin
      if (!gw_n) we = '1;
      else if (!bwe_n) we = ~bsel_n;
    end
    for (int i = 0; i < NL; i++)
      if (we[i]) m_mem[m_addr()][i*LW +: LW] = wd[i*LW +: LW];
    m_wr = |we;
  endtask

  task automatic check_now(input string tag);
    logic          ev;
    logic [WW-1:0] ed;
    ev = m_act && !m_wr && !oe_n && !zz && rst_n;
    ed = ev ? m_mem[m_addr()] : '0;
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      errors++;
      $display("FAIL %s rvalid=%b exp %b rdata=%h exp %h", tag, rvalid, ev, rdata, ed);
    end
  endtask

  task automatic chk_word(input string tag, input logic [WW-1:0] exp);
    checks++;
    if (rvalid !== 1'b1 || rdata !== exp) begin
      errors++;
      $display("FAIL %s rvalid=%b exp 1 rdata=%h exp %h", tag, rvalid, rdata, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    #1 model_edge();
    #1 check_now(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    ctl_n = 1; cpu_n = 1; sel_n = 0; step_n = 1; gw_n = 1; bwe_n = 1;
    bsel_n = '1; oe_n = 0; zz = 0; wd = '0;
  endtask

  task automatic load(input logic [AW-1:0] a, input string tag);
    idle(); ctl_n = 0; addr = a;
    tick(tag);
    idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] mixed;
    rst_n = 0; addr = '0; ord = 0; idle();
    m_base = '0; m_cnt = '0; m_act = 0; m_wr = 0;
    for (int a = 0; a < DEPTH; a++) m_mem[a] = 'x;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick("R12 reset");
    rst_n = 1;
    for (int i = 0; i < 3; i++) tick("R12 after reset");

    // fill array with global writes (R7)
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctl_n = 0; gw_n = 0; addr = AW'(a); wd = pat(AW'(a));
      tick("R7 fill");
    end
    idle();

    // linear burst from 0x0E with wrap (R4, R13, R6, R3)
    ord = 0;
    load(8'h0E, "R6 first beat");
    chk_word("R6 flow-through", pat(8'h0E));
    step_n = 0;
    tick("R4"); chk_word("R4 beat1", pat(8'h0F));
    tick("R4"); chk_word("R4 beat2", pat(8'h0C));
    tick("R4"); chk_word("R4 beat3", pat(8'h0D));
    tick("R13"); chk_word("R13 wrap", pat(8'h0E));
    step_n = 1;
    tick("R3"); chk_word("R3 hold", pat(8'h0E));

    // interleaved burst from 0x05 (R5, R13)
    ord = 1;
    load(8'h05, "R5 load");
    chk_word("R5 beat0", pat(8'h05));
    step_n = 0;
    tick("R5"); chk_word("R5 beat1", pat(8'h04));
    tick("R5"); chk_word("R5 beat2", pat(8'h07));
    tick("R5"); chk_word("R5 beat3", pat(8'h06));
    tick("R13"); chk_word("R13 interleaved wrap", pat(8'h05));
    ord = 0; idle();

    // controller strobe deselects, processor strobe ignored while deselected
    ctl_n = 0; sel_n = 1; addr = 8'h10;
    tick("R1 deselect");
    idle(); sel_n = 1; cpu_n = 0; addr = 8'h20;
    tick("R2 ignored");
    idle(); sel_n = 1;
    tick("R2 still deselected");
    idle(); cpu_n = 0; addr = 8'h20;
    tick("R2 load"); chk_word("R2 selected load", pat(8'h20));

    // controller strobe priority over advance
    idle(); step_n = 0; ctl_n = 0; addr = 8'h40;
    tick("R1 priority"); chk_word("R1 priority over step", pat(8'h40));

    // byte-lane write: lanes 0 and 2
    idle(); ctl_n = 0; addr = 8'h40; bwe_n = 0; bsel_n = 4'b1010; wd = 32'h11223344;
    tick("R8 write");
    mixed = pat(8'h40);
    mixed[7:0] = 8'h44; mixed[23:16] = 8'h22;
    load(8'h40, "R8 reload"); chk_word("R8 lanes", mixed);

    // neither enable: read, no change
    idle(); bsel_n = 4'b0000; wd = 32'hDEADBEEF;
    tick("R9 read"); chk_word("R9 unchanged", mixed);
    idle();

    // asynchronous output enable
    oe_n = 1; #1;
    checks++;
    if (rvalid !== 0 || rdata !== '0) begin
      errors++; $display("FAIL R10 rvalid=%b exp 0 rdata=%h exp 0", rvalid, rdata);
    end
    oe_n = 0; #1;
    chk_word("R10 restore", mixed);
    @(negedge clk);

    // sleep: ignore inputs, keep array and state
    zz = 1; ctl_n = 0; addr = 8'h80; gw_n = 0; wd = '0; #1;
    checks++;
    if (rvalid !== 0 || rdata !== '0) begin
      errors++; $display("FAIL R11 rvalid=%b exp 0 rdata=%h exp 0", rvalid, rdata);
    end
    @(negedge clk);
    tick("R11 asleep");
    idle();
    tick("R11 wake"); chk_word("R11 state kept", mixed);
    load(8'h80, "R11 reload"); chk_word("R11 array kept", pat(8'h80));

    // constrained random (R6 per cycle against the model)
    void'($urandom(32'h5EED));
    for (int n = 0; n < 3000; n++) begin
      ctl_n  = ($urandom % 6) != 0;
      cpu_n  = ($urandom % 6) != 0;
      sel_n  = ($urandom % 8) == 0;
      step_n = ($urandom % 2) != 0;
      gw_n   = ($urandom % 8) != 0;
      bwe_n  = ($urandom % 6) != 0;
      bsel_n = NL'($urandom);
      oe_n   = ($urandom % 8) == 0;
      zz     = ($urandom % 16) == 0;
      if (($urandom % 64) == 0) ord = ~ord;
      addr   = AW'($urandom);
      wd     = WW'($urandom);
      tick("R6 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule